// File: doc/BRIEF.md
# Memory-Mapped Address Decoder

This block sits on a processor's single 32-bit address bus and steers each access to one of four targets: a program ROM, a data RAM, a video frame memory and a page of device registers at the very top of the address space. For every request it raises at most one target select and hands that target an offset relative to the start of its window. Read data comes back combinationally from the selected target in the same cycle as the address.

Writes are turned into registered one-cycle strobes, together with the offset and data captured with them. The device page holds two registers of its own. One is a write-only terminal character port whose low byte is passed out with a valid pulse. The other is a read-only keyboard status flag that reports whether the input buffer is empty. An access in a direction a window does not allow is dropped and flagged. An access that hits no window is also dropped, and is flagged separately.

Top module: `mmap_decoder`

## Requirements
- R1: An access with addr_i in 0x00000000..0x0000FFFF raises rom_sel_o only, and a read there returns rom_rdata_i on rdata_o in the same cycle.
- R2: An access in 0x00100000..0x001FFFFF raises ram_sel_o only. A read returns ram_rdata_i. A write gives ram_we_o high for exactly the following cycle, with wr_addr_o = addr_i - 0x00100000 and wr_data_o = wdata_i.
- R3: An access in 0x01000000..0x010FFFFF raises vid_sel_o only. A write gives vid_we_o high for the following cycle, with wr_addr_o = addr_i - 0x01000000 and wr_data_o = wdata_i.
- R4: An access in 0xFFFFFF00..0xFFFFFFFF raises io_sel_o only. A write to 0xFFFFFF00 gives term_valid_o high for the following cycle, with term_char_o = wdata_i[7:0].
- R5: A read of 0xFFFFFF18 returns kbd_empty_i in bit 0 and zero in bits 31:1.
- R6: The following accesses are direction violations: a write to the ROM window, a write to 0xFFFFFF18, a read of the video window, and a read of 0xFFFFFF00. A violation produces no write strobe and no terminal pulse, a read that is a violation returns zero, and dir_err_o is high for the following cycle.
- R7: An access outside all four windows raises no select, returns zero on a read, produces no strobe, and gives unmapped_o high for the following cycle.
- R8: local_addr_o equals addr_i minus the base of the selected window, and is zero when no window is selected.
- R9: At most one select is high at a time. When req_i is low, all selects, rdata_o and local_addr_o are zero, and no strobe or flag follows. After reset, every registered output is zero.
- R10: Reads of other offsets in the device page return zero. Writes to them have no effect. Neither raises a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| rom_rdata_i | input | 32 | ROM read data |
| ram_rdata_i | input | 32 | RAM read data |
| kbd_empty_i | input | 1 | Keyboard buffer empty |
| rom_sel_o | output | 1 | ROM select |
| ram_sel_o | output | 1 | RAM select |
| vid_sel_o | output | 1 | Video select |
| io_sel_o | output | 1 | Device page select |
| local_addr_o | output | 32 | Window-relative address |
| ram_we_o | output | 1 | Registered RAM write strobe |
| vid_we_o | output | 1 | Registered video write strobe |
| wr_addr_o | output | 32 | Registered write offset |
| wr_data_o | output | 32 | Registered write data |
| term_valid_o | output | 1 | Terminal character pulse |
| term_char_o | output | 8 | Terminal character |
| dir_err_o | output | 1 | Direction violation pulse |
| unmapped_o | output | 1 | Unmapped access pulse |

## Verification
Two kinds of fault show up here. A wrong window boundary or base shows at the ports in the same cycle: a select goes to the wrong target, the offset is wrong, or read data comes from the wrong source, most often at the first or last byte of a window. A corrupted strobe or flag register shows one cycle after the access: a strobe or pulse is missing, appears where it should not, or persists past a single cycle. The sweep therefore probes each window's edge bytes and a stride across the whole address space, in both directions. It also walks the device page offset by offset.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int NREG    = 4;
  localparam int IDX_ROM = 0;
  localparam int IDX_RAM = 1;
  localparam int IDX_VID = 2;
  localparam int IDX_IO  = 3;
  localparam logic [31:0] REG_BASE [NREG] =
    '{32'h0000_0000, 32'h0010_0000, 32'h0100_0000, 32'hFFFF_FF00};
  localparam int REG_LOG2 [NREG] = '{16, 20, 20, 8};
  // bit i: window i permits that direction
  localparam logic [NREG-1:0] REG_RD_OK = 4'b1011;
  localparam logic [NREG-1:0] REG_WR_OK = 4'b1110;
  localparam int IO_OFS_W = 8;
  localparam logic [IO_OFS_W-1:0] TERM_OFS = 8'h00;
  localparam logic [IO_OFS_W-1:0] KBD_OFS  = 8'h18;
endpackage

// File: rtl/mmap_window_decode.sv
module mmap_window_decode
  import mmap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic [NREG-1:0] hit_o,
  output logic [AW-1:0] local_o
);
  logic [AW-1:0] ofs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_win
    localparam int LG = REG_LOG2[i];
    localparam logic [AW-1:0] BASE = AW'(REG_BASE[i]);
    assign hit_o[i] = req_i && (addr_i[AW-1:LG] == BASE[AW-1:LG]);
    assign ofs[i]   = hit_o[i] ? (addr_i - BASE) : '0;
  end

  always_comb begin
    local_o = '0;
    for (int i = 0; i < NREG; i++) local_o |= ofs[i];
  end
endmodule

// File: rtl/mmap_io_regs.sv
module mmap_io_regs
  import mmap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [IO_OFS_W-1:0] ofs_i,
  input  logic [7:0]          wbyte_i,
  input  logic                kbd_empty_i,
  output logic [DW-1:0]       rdata_o,
  output logic                dir_err_o,
  output logic                term_valid_o,
  output logic [7:0]          term_char_o
);
  logic term_hit, kbd_hit;
  assign term_hit  = sel_i && (ofs_i == TERM_OFS);
  assign kbd_hit   = sel_i && (ofs_i == KBD_OFS);
  assign rdata_o   = (kbd_hit && !we_i) ? DW'(kbd_empty_i) : '0;
  assign dir_err_o = we_i ? kbd_hit : term_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_valid_o <= 1'b0;
      term_char_o  <= '0;
    end else begin
      term_valid_o <= term_hit && we_i;
      if (term_hit && we_i) term_char_o <= wbyte_i;
    end
  end

  AST_TERM_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_valid_o |-> $past(sel_i && we_i && ofs_i == TERM_OFS)); // R4
  AST_KBD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && ofs_i == KBD_OFS) |-> (rdata_o[0] == kbd_empty_i && rdata_o[DW-1:1] == '0)); // R5
endmodule

// File: rtl/mmap_write_port.sv
module mmap_write_port
  import mmap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [NREG-1:0] hit_i,
  input  logic [AW-1:0]   local_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            io_dir_err_i,
  output logic            ram_we_o,
  output logic            vid_we_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            dir_err_o,
  output logic            unmapped_o
);
  logic ram_wr, vid_wr, bad_dir, miss;
  assign ram_wr  = req_i && we_i && hit_i[IDX_RAM];
  assign vid_wr  = req_i && we_i && hit_i[IDX_VID];
  assign bad_dir = req_i && (io_dir_err_i ||
                   (we_i  && |(hit_i & ~REG_WR_OK)) ||
                   (!we_i && |(hit_i & ~REG_RD_OK)));
  assign miss    = req_i && (hit_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_we_o   <= 1'b0;
      vid_we_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      dir_err_o  <= 1'b0;
      unmapped_o <= 1'b0;
    end else begin
      ram_we_o   <= ram_wr;
      vid_we_o   <= vid_wr;
      dir_err_o  <= bad_dir;
      unmapped_o <= miss;
      if (ram_wr || vid_wr) begin
        wr_addr_o <= local_i;
        wr_data_o <= wdata_i;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && vid_we_o)); // R9
  AST_ROM_WR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit_i[IDX_ROM]) |=> (dir_err_o && !ram_we_o && !vid_we_o)); // R6
  AST_MISS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> $past(hit_i == '0)); // R7
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rom_rdata_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic          kbd_empty_i,
  output logic          rom_sel_o,
  output logic          ram_sel_o,
  output logic          vid_sel_o,
  output logic          io_sel_o,
  output logic [AW-1:0] local_addr_o,
  output logic          ram_we_o,
  output logic          vid_we_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          term_valid_o,
  output logic [7:0]    term_char_o,
  output logic          dir_err_o,
  output logic          unmapped_o
);
  logic [NREG-1:0] hit;
  logic [DW-1:0]   io_rdata;
  logic            io_dir_err;
  logic            rd;

  mmap_window_decode #(.AW(AW)) u_dec (
    .req_i  (req_i),
    .addr_i (addr_i),
    .hit_o  (hit),
    .local_o(local_addr_o)
  );

  mmap_io_regs #(.DW(DW)) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (hit[IDX_IO]),
    .we_i        (we_i),
    .ofs_i       (local_addr_o[IO_OFS_W-1:0]),
    .wbyte_i     (wdata_i[7:0]),
    .kbd_empty_i (kbd_empty_i),
    .rdata_o     (io_rdata),
    .dir_err_o   (io_dir_err),
    .term_valid_o(term_valid_o),
    .term_char_o (term_char_o)
  );

  mmap_write_port #(.AW(AW), .DW(DW)) u_wp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .hit_i       (hit),
    .local_i     (local_addr_o),
    .wdata_i     (wdata_i),
    .io_dir_err_i(io_dir_err),
    .ram_we_o    (ram_we_o),
    .vid_we_o    (vid_we_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .dir_err_o   (dir_err_o),
    .unmapped_o  (unmapped_o)
  );

  assign rom_sel_o = hit[IDX_ROM];
  assign ram_sel_o = hit[IDX_RAM];
  assign vid_sel_o = hit[IDX_VID];
  assign io_sel_o  = hit[IDX_IO];

  assign rd = req_i && !we_i;
  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (1'b1)
        hit[IDX_ROM]: rdata_o = rom_rdata_i;
        hit[IDX_RAM]: rdata_o = ram_rdata_i;
        hit[IDX_IO]:  rdata_o = io_rdata;
        default:      rdata_o = '0;
      endcase
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o, vid_sel_o, io_sel_o})); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0 && local_addr_o == '0 && !rom_sel_o && !io_sel_o)); // R9
  AST_VID_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && vid_sel_o) |-> (rdata_o == '0)); // R6
  AST_RAM_OFS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o |-> (local_addr_o < (AW'(1) << REG_LOG2[IDX_RAM]))); // R8
  AST_RAM_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ram_sel_o) |=> (ram_we_o && wr_data_o == $past(wdata_i))); // R2
endmodule

// File: tb/mmap_decoder_test.sv
module mmap_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, kbd = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rom_d = 32'hC0DE_0001, ram_d = 32'hBEEF_0002;
  logic [31:0] rdata, local_addr, wr_addr, wr_data;
  logic        rom_sel, ram_sel, vid_sel, io_sel, ram_we, vid_we, term_v, dir_err, unmapped;
  logic [7:0]  term_c;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmap_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rom_rdata_i(rom_d), .ram_rdata_i(ram_d),
    .kbd_empty_i(kbd), .rom_sel_o(rom_sel), .ram_sel_o(ram_sel), .vid_sel_o(vid_sel),
    .io_sel_o(io_sel), .local_addr_o(local_addr), .ram_we_o(ram_we), .vid_we_o(vid_we),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .term_valid_o(term_v), .term_char_o(term_c),
    .dir_err_o(dir_err), .unmapped_o(unmapped)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h we=%0b act=%h exp=%h", req_tag, addr, we, act, exp);
    end
  endtask

  function automatic int win_of(logic [31:0] a);
    if (a <= 32'h0000_FFFF) return 0;
    if (a >= 32'h0010_0000 && a <= 32'h001F_FFFF) return 1;
    if (a >= 32'h0100_0000 && a <= 32'h010F_FFFF) return 2;
    if (a >= 32'hFFFF_FF00) return 3;
    return -1;
  endfunction

  function automatic logic [31:0] base_of(int w);
    case (w)
      0: return 32'h0000_0000;
      1: return 32'h0010_0000;
      2: return 32'h0100_0000;
      default: return 32'hFFFF_FF00;
    endcase
  endfunction

  task automatic access(logic [31:0] a, logic w, logic [31:0] d);
    int r;
    logic [7:0] o;
    logic [31:0] exp_rd;
    logic ebad;
    r = win_of(a);
    o = a[7:0];
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    chk("R9_sel", {28'b0, io_sel, vid_sel, ram_sel, rom_sel}, (r >= 0) ? (32'd1 << r) : 32'd0);
    chk("R8_local", local_addr, (r >= 0) ? a - base_of(r) : 32'd0);
    if (!w) begin
      exp_rd = 32'd0;
      if (r == 0) exp_rd = rom_d;
      if (r == 1) exp_rd = ram_d;
      if (r == 3 && o == 8'h18) exp_rd = {31'b0, kbd};
      chk(r == 0 ? "R1_rd" : r == 1 ? "R2_rd" : r == 3 ? "R5_R10_rd" : r == 2 ? "R6_rd" : "R7_rd",
          rdata, exp_rd);
    end
    ebad = w ? (r == 0 || (r == 3 && o == 8'h18)) : (r == 2 || (r == 3 && o == 8'h00));
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1;
    chk("R2_we", {31'b0, ram_we}, {31'b0, w && r == 1});
    chk("R3_we", {31'b0, vid_we}, {31'b0, w && r == 2});
    chk("R4_term", {31'b0, term_v}, {31'b0, w && r == 3 && o == 8'h00});
    if (w && r == 3 && o == 8'h00) chk("R4_char", {24'b0, term_c}, {24'b0, d[7:0]});
    if (w && (r == 1 || r == 2)) begin
      chk("R2_R3_waddr", wr_addr, a - base_of(r));
      chk("R2_R3_wdata", wr_data, d);
    end
    chk("R6_dir", {31'b0, dir_err}, {31'b0, ebad});
    chk("R7_unmapped", {31'b0, unmapped}, {31'b0, r < 0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9_rst", {26'b0, ram_we, vid_we, term_v, dir_err, unmapped, 1'b0}, 32'd0);
    chk("R9_rst_w", wr_addr | wr_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 32'h0010_0040; #1;
    chk("R9_idle_sel", {28'b0, io_sel, vid_sel, ram_sel, rom_sel}, 32'd0);
    chk("R9_idle_rd", rdata, 32'd0);
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] b, a;
        b = base_of(w);
        case (k)
          0: a = b;
          1: a = b + 1;
          2: a = b + ((32'd1 << (w == 0 ? 16 : w == 3 ? 8 : 20)) - 1);
          3: a = b + (32'd1 << (w == 0 ? 16 : w == 3 ? 8 : 20));
          4: a = b - 1;
          default: a = b + 32'h84;
        endcase
        for (int d = 0; d < 2; d++) begin
          kbd = ~kbd;
          access(a, d[0], 32'h5A00_0000 ^ a ^ {24'b0, 8'(k * 37 + w)});
        end
      end
    end
    for (int k = 0; k < 64; k++) begin
      access(32'h0404_0409 * k, 1'b0, 32'd0);
      access(32'h0404_0409 * k, 1'b1, 32'h1234_0000 + k);
    end
    for (int o = 0; o < 256; o += 4) begin
      kbd = o[2];
      access(32'hFFFF_FF00 + o, 1'b0, 32'd0);
      access(32'hFFFF_FF00 + o, 1'b1, 32'hA5A5_A500 | o);
    end
    access(32'hFFFF_FF00, 1'b1, 32'h0000_0041);
    access(32'hFFFF_FF05, 1'b1, 32'h0000_0042);
    rom_d = 32'h0BAD_F00D; ram_d = 32'h7777_1234;
    access(32'h0000_1234, 1'b0, 32'd0);
    access(32'h0018_0000, 1'b0, 32'd0);
    @(negedge clk); #1;
    chk("R9_quiet", {30'b0, ram_we, term_v}, 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule